// File: doc/BRIEF.md
# Single-Neuron Keystream Cipher Datapath

This block is a fixed-weight neural keystream generator combined with a stream-cipher mixer. Each accepted 8-bit binary pattern goes through one hidden neuron and one output neuron, and the result is one keystream bit. That bit is XORed with a plaintext bit, which is supplied alongside the pattern, to form one ciphertext bit. Running the same pattern with the ciphertext as the plaintext recovers the original bit, so a single instance both encrypts and decrypts.

All weights and biases are fixed-point constants given as parameters. They use 13 fraction bits and a 14-bit two's-complement width. Because every input is a single bit, each weight either joins the hidden sum or does not, so no multipliers are needed there. The hidden activation is a piecewise second-order sigmoid with no table. The activation works in four named zones:

- floor: the input is at or below −4.
- lower: the input is between −4 and 0.
- upper: the input is between 0 and 4.
- ceiling: the input is at or above 4.

The output neuron uses the same activation and then a binary step. The datapath is a three-stage pipeline with a fixed latency and can accept one pattern per clock.

Top module: `nkc_keystream_cipher`

## Requirements
- R1: The hidden pre-activation equals the hidden bias plus the sum of the weights whose pattern bit is 1. Weight i occupies bits [14*i+13 : 14*i] of the packed weight parameter and pairs with pattern bit i. All values are in units of 2^-13.
- R2: The activation of an integer input x (scale 2^13, one = 8192) behaves as follows:
  - It is 8192 when x ≥ 32768.
  - It is 0 when x ≤ −32768.
  - For 0 ≤ x < 32768 it is 8192 − floor(u²/16384), with u = 8192 − floor(x/4).
  - For −32768 < x < 0 it is floor(v²/16384), with v = 8192 + floor(x/4).
- R3: The output pre-activation equals the output bias plus floor(w·h/8192), where w is the output weight and h is the hidden activation.
- R4: The keystream bit is 1 exactly when the output activation (R2 applied to the R3 value) is at least 4096.
- R5: The ciphertext bit equals the plaintext bit sampled with the pattern XOR the keystream bit for that pattern.
- R6: The keystream valid output is high exactly three rising edges after a pattern is sampled. Patterns can be accepted on every cycle, and results appear in input order.
- R7: While keystream valid is low, both the keystream bit and the ciphertext bit are 0.
- R8: During reset, and directly after it, keystream valid, keystream bit and ciphertext bit are all 0.
- R9: Feeding a ciphertext bit back as plaintext with the same pattern returns the original plaintext bit.
- R10: A hidden pre-activation of 32768 or more gives a hidden activation of exactly 8192, which is the ceiling zone. With the default weights, pattern 0x55 reaches this zone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | Pattern and plaintext bit are sampled this cycle |
| pat | input | NIN (8) | Binary input pattern, one bit per input neuron |
| plain_bit | input | 1 | Plaintext (or ciphertext, to decrypt) bit paired with the pattern |
| ks_valid | output | 1 | Keystream and ciphertext bits are valid |
| ks_bit | output | 1 | Keystream bit |
| cipher_bit | output | 1 | Plaintext bit XOR keystream bit |

## Verification
Several properties are checked by assertions on every cycle:
- the three-edge link between pattern valid and keystream valid;
- the XOR relation between the ciphertext, the keystream and the delayed plaintext bit;
- quiet outputs while not valid, and clear outputs after reset;
- activation values that never exceed one.

The numeric results cannot be covered by cycle properties. These are the gated hidden sum, the exact quadratic values in each zone, the scaled output product and the step threshold. Only the bench's scenarios show them: all 256 patterns back to back, gapped traffic, the saturating pattern, and an encrypt-then-decrypt round trip.

// File: rtl/nkc_pkg.sv
package nkc_pkg;

    // Zones of the piecewise quadratic activation
    typedef enum logic [1:0] {
        ZONE_FLOOR,
        ZONE_LOWER,
        ZONE_UPPER,
        ZONE_CEIL
    } act_zone_e;

endpackage

// File: rtl/nkc_gated_sum.sv
module nkc_gated_sum #(
    parameter int NIN = 8,
    parameter int WW  = 14,
    parameter int SW  = 18
) (
    input  logic [NIN-1:0]        bits,
    input  logic [NIN*WW-1:0]     wts,
    input  logic signed [WW-1:0]  bias,
    output logic signed [SW-1:0]  sum
);

    logic signed [SW-1:0] part [NIN+1];

    assign part[0] = SW'(bias);

    // One conditional add per input: a 1-bit input selects weight or zero
    for (genvar i = 0; i < NIN; i++) begin : g_tap
        logic signed [WW-1:0] w_i;
        assign w_i       = $signed(wts[i*WW +: WW]);
        assign part[i+1] = part[i] + (bits[i] ? SW'(w_i) : SW'(0));
    end

    assign sum = part[NIN];

endmodule

// File: rtl/nkc_pw_sigmoid.sv
module nkc_pw_sigmoid
    import nkc_pkg::*;
#(
    parameter int IW   = 18,
    parameter int FRAC = 13
) (
    input  logic signed [IW-1:0] x,
    output logic [FRAC:0]        y
);

    localparam logic signed [IW-1:0] ONE_S  = IW'(1 << FRAC);
    localparam logic signed [IW-1:0] SAT_HI = IW'(4 << FRAC);
    localparam logic signed [IW-1:0] SAT_LO = -SAT_HI;
    localparam logic [FRAC:0]        ONE_U  = (FRAC+1)'(1 << FRAC);
    localparam int                   SQW    = 2*FRAC + 2;

    act_zone_e             zone;
    logic signed [IW-1:0]  quarter;
    logic signed [IW-1:0]  base_s;
    logic [FRAC:0]         base;
    logic [SQW-1:0]        sq;
    logic [FRAC:0]         half_sq;

    assign quarter = x >>> 2;

    always_comb begin
        if (x >= SAT_HI)      zone = ZONE_CEIL;
        else if (x <= SAT_LO) zone = ZONE_FLOOR;
        else if (x >= 0)      zone = ZONE_UPPER;
        else                  zone = ZONE_LOWER;
    end

    // distance term of the quadratic: 1 - x/4 above zero, 1 + x/4 below
    assign base_s  = (zone == ZONE_UPPER) ? (ONE_S - quarter) : (ONE_S + quarter);
    assign base    = (FRAC+1)'(base_s);
    assign sq      = SQW'(base) * SQW'(base);
    assign half_sq = (FRAC+1)'(sq >> (FRAC + 1));

    always_comb begin
        unique case (zone)
            ZONE_FLOOR: y = '0;
            ZONE_LOWER: y = half_sq;
            ZONE_UPPER: y = ONE_U - half_sq;
            ZONE_CEIL:  y = ONE_U;
            default:    y = '0;
        endcase
    end

    // R2 / R10: activation never exceeds one
    always_comb begin
        if (!$isunknown(x)) begin
            a_r2_act_bound: assert (y <= ONE_U)
                else $error("activation above one");
        end
    end

endmodule

// File: rtl/nkc_keystream_cipher.sv
module nkc_keystream_cipher #(
    parameter int NIN  = 8,
    parameter int WW   = 14,
    parameter int FRAC = 13,
    parameter logic [NIN*WW-1:0] W_HID = {
        -14'sd5800, 14'sd6200, -14'sd6500, 14'sd6900,
        -14'sd7000, 14'sd7500, -14'sd7900, 14'sd8000 },
    parameter logic signed [WW-1:0] B_HID = 14'sd4500,
    parameter logic signed [WW-1:0] V_OUT = -14'sd8000,
    parameter logic signed [WW-1:0] B_OUT = 14'sd3000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pat_valid,
    input  logic [NIN-1:0] pat,
    input  logic           plain_bit,
    output logic           ks_valid,
    output logic           ks_bit,
    output logic           cipher_bit
);

    localparam int SW   = WW + $clog2(NIN + 1);
    localparam int PW   = WW + FRAC + 2;
    localparam int HALF = 1 << (FRAC - 1);

    // stage registers
    logic                  s1_valid, s2_valid;
    logic                  s1_plain, s2_plain;
    logic signed [SW-1:0]  s1_sum;
    logic [FRAC:0]         s2_h;

    logic signed [SW-1:0]  hid_sum;
    logic [FRAC:0]         hid_act;
    logic signed [PW-1:0]  prod;
    logic signed [SW-1:0]  out_pre;
    logic [FRAC:0]         out_act;
    logic                  step;

    nkc_gated_sum #(.NIN(NIN), .WW(WW), .SW(SW)) u_sum (
        .bits (pat),
        .wts  (W_HID),
        .bias (B_HID),
        .sum  (hid_sum)
    );

    nkc_pw_sigmoid #(.IW(SW), .FRAC(FRAC)) u_hid_act (
        .x (s1_sum),
        .y (hid_act)
    );

    assign prod    = PW'(V_OUT) * PW'($signed({1'b0, s2_h}));
    assign out_pre = SW'(B_OUT) + SW'(prod >>> FRAC);

    nkc_pw_sigmoid #(.IW(SW), .FRAC(FRAC)) u_out_act (
        .x (out_pre),
        .y (out_act)
    );

    assign step = (out_act >= (FRAC+1)'(HALF));

    // control: valid flags move one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
            ks_valid <= 1'b0;
        end else begin
            s1_valid <= pat_valid;
            s2_valid <= s1_valid;
            ks_valid <= s2_valid;
        end
    end

    // data: sum, hidden activation, then output step and XOR
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum     <= '0;
            s1_plain   <= 1'b0;
            s2_h       <= '0;
            s2_plain   <= 1'b0;
            ks_bit     <= 1'b0;
            cipher_bit <= 1'b0;
        end else begin
            s1_sum     <= hid_sum;
            s1_plain   <= plain_bit;
            s2_h       <= hid_act;
            s2_plain   <= s1_plain;
            ks_bit     <= s2_valid & step;
            cipher_bit <= s2_valid & (step ^ s2_plain);
        end
    end

    // cycles since reset, saturating, so history checks stay inside it
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (ks_valid == $past(pat_valid, 3)))
        else $error("keystream valid not three edges after pattern");

    a_r5_cipher_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && ks_valid) |-> ((cipher_bit ^ ks_bit) == $past(plain_bit, 3)))
        else $error("ciphertext is not plaintext xor keystream");

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid |-> (!ks_bit && !cipher_bit))
        else $error("outputs active while not valid");

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ks_valid && !s1_valid && !s2_valid))
        else $error("pipeline not clear after reset");

    a_r2_hidden_range: assert property (@(posedge clk) disable iff (!rst_n)
        s2_h <= (FRAC+1)'(1 << FRAC))
        else $error("hidden activation above one");

endmodule

// File: tb/sim_nkc_keystream_cipher.sv
module sim_nkc_keystream_cipher;

    localparam int WV [8] = '{8000, -7900, 7500, -7000, 6900, -6500, 6200, -5800};
    localparam int BH = 4500;
    localparam int VO = -8000;
    localparam int BO = 3000;
    localparam logic [111:0] WP = {
        14'(WV[7]), 14'(WV[6]), 14'(WV[5]), 14'(WV[4]),
        14'(WV[3]), 14'(WV[2]), 14'(WV[1]), 14'(WV[0]) };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pat_valid;
    logic [7:0] pat;
    logic       plain_bit;
    logic       ks_valid, ks_bit, cipher_bit;

    always #2.5 clk = ~clk;

    nkc_keystream_cipher #(
        .NIN(8), .WW(14), .FRAC(13), .W_HID(WP),
        .B_HID(14'(BH)), .V_OUT(14'(VO)), .B_OUT(14'(BO))
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat(pat),
        .plain_bit(plain_bit), .ks_valid(ks_valid), .ks_bit(ks_bit),
        .cipher_bit(cipher_bit)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run_mon = 0;
    bit done    = 0;

    int    due_q[$];
    bit    ks_q[$];
    bit    ct_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---- reference model from the requirements ----
    function automatic int fdiv(input int a, input int b);
        if (a >= 0) return a / b;
        return -((-a + b - 1) / b);
    endfunction

    function automatic int act(input int x);
        int u;
        if (x >= 32768)  return 8192;
        if (x <= -32768) return 0;
        if (x >= 0) begin
            u = 8192 - fdiv(x, 4);
            return 8192 - fdiv(u * u, 16384);
        end
        u = 8192 + fdiv(x, 4);
        return fdiv(u * u, 16384);
    endfunction

    function automatic bit model_ks(input logic [7:0] p);
        int s, h, y;
        s = BH;
        for (int i = 0; i < 8; i++) if (p[i]) s += WV[i];
        h = act(s);
        y = BO + fdiv(VO * h, 8192);
        return act(y) >= 4096;
    endfunction

    // ---- driver ----
    task automatic send(input logic [7:0] p, input bit b, input string tag);
        bit k;
        @(negedge clk);
        pat = p; plain_bit = b; pat_valid = 1'b1;
        k = model_ks(p);
        due_q.push_back(cyc + 3);
        ks_q.push_back(k);
        ct_q.push_back(k ^ b);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pat_valid = 1'b0;
            pat = 8'h00;
            plain_bit = 1'b0;
        end
    endtask

    // ---- monitor / scoreboard ----
    always @(negedge clk) begin
        if (run_mon && !done) begin
            if (ks_valid) begin
                if (due_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected valid", 1, 0);
                end else begin
                    int    d;
                    bit    ek, ec;
                    string t;
                    d = due_q.pop_front(); ek = ks_q.pop_front();
                    ec = ct_q.pop_front(); t = tag_q.pop_front();
                    chk(cyc == d, "R6 latency", cyc, d);
                    chk(ks_bit == ek, {t, " keystream"}, ks_bit, ek);
                    chk(cipher_bit == ec, "R5 ciphertext", cipher_bit, ec);
                end
            end else begin
                chk(!ks_bit && !cipher_bit, "R7 quiet while invalid",
                    {ks_bit, cipher_bit}, 0);
                if (due_q.size() != 0 && due_q[0] <= cyc)
                    chk(1'b0, "R6 missing result", 0, 1);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit c;
        rst_n = 1'b0; pat_valid = 1'b0; pat = 8'h00; plain_bit = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state, with a pattern offered during reset
        pat_valid = 1'b1; pat = 8'hFF; plain_bit = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ks_valid, "R8 valid in reset", ks_valid, 0);
        chk(!ks_bit && !cipher_bit, "R8 data in reset", {ks_bit, cipher_bit}, 0);
        pat_valid = 1'b0; pat = 8'h00; plain_bit = 1'b0;
        rst_n = 1'b1;
        run_mon = 1;
        repeat (3) @(negedge clk);
        chk(!ks_valid, "R8 valid after reset", ks_valid, 0);

        // R1 R2 R3 R4 R6: all patterns back to back; 0x55 saturates (R10)
        for (int i = 0; i < 256; i++)
            send(8'(i), i[0] ^ i[3] ^ i[5], (i == 8'h55) ? "R10" : "R1 R2 R3 R4");
        idle(1);

        // gapped traffic, R7 exercised in the gaps
        send(8'hA3, 1'b1, "R4"); idle(2);
        send(8'h3C, 1'b0, "R4"); idle(4);
        send(8'h55, 1'b1, "R10"); send(8'h00, 1'b1, "R2"); idle(5);

        // R9: round trip through the same pattern
        foreach (WV[j]) begin
            logic [7:0] p;
            p = 8'(8'h0F << (j % 5)) ^ 8'(j * 37);
            for (int b = 0; b < 2; b++) begin
                send(p, b[0], "R9 enc"); idle(3);
                c = cipher_bit;
                send(p, c, "R9 dec"); idle(3);
                chk(cipher_bit == b[0], "R9 decrypt", cipher_bit, b);
            end
        end

        idle(6);
        chk(due_q.size() == 0, "R6 results outstanding", due_q.size(), 0);
        finish_run();
    end

endmodule